// File: doc/BRIEF.md
# DS3 C-bit overhead generator

This block supplies the overhead value for each of the 21 C-bit slots of a DS3 M-frame when the line runs in C-bit parity mode. The framer addresses a slot by its subframe number (1 to 7) and its position inside the subframe (1 to 3). The block decodes that address into a slot role and returns the matching bit on the same cycle. The roles are: identification, reserved, alarm channel, parity, far-end block error, maintenance data link, and undefined.

The parity value and the alarm-channel bit come from outside the block. The block-error bits come from receive-side error flags, which are latched over each M-frame. Data-link bits are pulled from a serial source through a ready/valid handshake, one bit per data-link slot.

A separate output tells the DS2-to-DS3 multiplexer whether to use each stuff opportunity. It follows a fixed pattern of 7 stuffs in every 18 opportunities.

Top module: `dsc_cbit_gen`

## Requirements
- R1: For a request to C-bit number 1 (subframe 1, position 1, the identification slot) or C-bit number 2 (subframe 1, position 2, reserved), `cbit_out` is 1 on the same cycle. The C-bit number is 3×(subframe−1)+position.
- R2: For a request to C-bit 3 (subframe 1, position 3), `cbit_out` equals `feac_bit` on the same cycle.
- R3: For a request to any position of subframe 3 (C-bits 7, 8 and 9), `cbit_out` equals `parity_bit` on the same cycle.
- R4: For a request to any position of subframe 4 (C-bits 10 to 12), `cbit_out` is 0 in two cases. The first is that `rx_par_err` or `rx_frm_err` was high in some cycle of the previous M-frame. That frame runs from the cycle after one `mframe_start` up to and including the cycle of the next one. The second case is the same for the frame held since reset. Otherwise `cbit_out` is 1, and it is 1 after reset.
- R5: The block-error value changes only in the cycle after an `mframe_start`. An error flagged between boundaries leaves it unchanged until the next boundary. Each boundary starts a fresh error collection.
- R6: For a request to any position of subframe 5 (C-bits 13 to 15), `dl_ready` is 1 on the same cycle. `cbit_out` then equals `dl_data` when `dl_valid` is 1, and is 1 when `dl_valid` is 0. A bit is consumed only when `dl_ready` and `dl_valid` are both high.
- R7: For a request to C-bits 4 to 6 (subframe 2) or 16 to 21 (subframes 6 and 7), `cbit_out` is 1.
- R8: When `slot_req` is 0, or when the subframe is outside 1 to 7, or when the position is outside 1 to 3, `cbit_out` is 1 and `dl_ready` is 0.
- R9: `stuff_en` shows the decision for the next stuff opportunity. It changes only in the cycle after a `stuff_opp` pulse. Counting opportunities from 0 after reset, it is high exactly at indices 2, 5, 7, 10, 12, 15 and 17 of every group of 18. That is 7 stuffs in every 18 opportunities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_req | input | 1 | Framer asks for a C-bit value this cycle |
| slot_sub | input | 3 | Subframe number, 1 to 7 |
| slot_pos | input | 2 | Position in subframe, 1 to 3 |
| mframe_start | input | 1 | One-cycle pulse at each M-frame boundary |
| parity_bit | input | 1 | Parity value for the parity slots |
| feac_bit | input | 1 | Alarm-channel bit from the control register |
| rx_par_err | input | 1 | Receive side saw a C-bit parity error |
| rx_frm_err | input | 1 | Receive side saw a framing error |
| dl_data | input | 1 | Serial data-link bit |
| dl_valid | input | 1 | Data-link bit is available |
| dl_ready | output | 1 | Data-link bit is taken this cycle |
| stuff_opp | input | 1 | One-cycle pulse at each stuff opportunity |
| stuff_en | output | 1 | Use the coming stuff opportunity |
| cbit_out | output | 1 | C-bit value for the requested slot |

## Verification
The assertions check the slot mapping on every cycle, directly from the subframe and position inputs. They cover the alarm, parity, data-link and out-of-range slots and the idle state. They also check that the block-error value and the stuff decision move only after their strobes. A windowed counter confirms that every group of 18 opportunities holds exactly 7 stuffs.

Some behaviours can only be shown by the bench's scenarios. One is which frame an error is credited to, including an error that lands on the boundary cycle itself. Another is that the data-link fill is 1 when no data is offered. The last is that the stuff pattern falls at the exact positions across two full groups.

// File: rtl/dsc_cbit_pkg.sv
package dsc_cbit_pkg;

   typedef enum logic [2:0] {
      ROLE_NONE  = 3'd0,
      ROLE_ID    = 3'd1,
      ROLE_RSV   = 3'd2,
      ROLE_FEAC  = 3'd3,
      ROLE_PAR   = 3'd4,
      ROLE_FEBE  = 3'd5,
      ROLE_DL    = 3'd6,
      ROLE_UNDEF = 3'd7
   } slot_role_e;

   localparam int unsigned CB_ID      = 1;
   localparam int unsigned CB_RSV     = 2;
   localparam int unsigned CB_FEAC    = 3;
   localparam int unsigned CB_PAR_LO  = 7;
   localparam int unsigned CB_PAR_HI  = 9;
   localparam int unsigned CB_FEBE_LO = 10;
   localparam int unsigned CB_FEBE_HI = 12;
   localparam int unsigned CB_DL_LO   = 13;
   localparam int unsigned CB_DL_HI   = 15;
   localparam int unsigned CB_TOTAL   = 21;

   function automatic slot_role_e role_of(input int unsigned cnum);
      slot_role_e r;
      if (cnum == 0 || cnum > CB_TOTAL)                     r = ROLE_NONE;
      else if (cnum == CB_ID)                               r = ROLE_ID;
      else if (cnum == CB_RSV)                              r = ROLE_RSV;
      else if (cnum == CB_FEAC)                             r = ROLE_FEAC;
      else if (cnum >= CB_PAR_LO && cnum <= CB_PAR_HI)      r = ROLE_PAR;
      else if (cnum >= CB_FEBE_LO && cnum <= CB_FEBE_HI)    r = ROLE_FEBE;
      else if (cnum >= CB_DL_LO && cnum <= CB_DL_HI)        r = ROLE_DL;
      else                                                  r = ROLE_UNDEF;
      return r;
   endfunction

endpackage

// File: rtl/dsc_slot_decode.sv
module dsc_slot_decode
   import dsc_cbit_pkg::*;
#(
   parameter int unsigned SUB_W = 3,
   parameter int unsigned POS_W = 2,
   parameter int unsigned N_SUB = 7,
   parameter int unsigned N_POS = 3
) (
   input  logic             req,
   input  logic [SUB_W-1:0] sub,
   input  logic [POS_W-1:0] pos,
   output slot_role_e       role
);

   localparam int unsigned CN_W = $clog2(N_SUB*N_POS + 1);

   generate
      if (N_SUB >= (1 << SUB_W)) begin : g_bad_sub
         $error("SUB_W too narrow for N_SUB");
      end
      if (N_POS >= (1 << POS_W)) begin : g_bad_pos
         $error("POS_W too narrow for N_POS");
      end
   endgenerate

   logic            sub_ok;
   logic            pos_ok;
   logic [CN_W-1:0] cnum;

   always_comb begin
      sub_ok = (sub >= SUB_W'(1)) && (sub <= SUB_W'(N_SUB));
      pos_ok = (pos >= POS_W'(1)) && (pos <= POS_W'(N_POS));
      cnum   = (CN_W'(sub) - CN_W'(1)) * CN_W'(N_POS) + CN_W'(pos);
      if (req && sub_ok && pos_ok) role = role_of(int'(cnum));
      else                         role = ROLE_NONE;
   end

endmodule

// File: rtl/dsc_febe_latch.sv
module dsc_febe_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic mframe_start,
   input  logic rx_par_err,
   input  logic rx_frm_err,
   output logic febe_bit
);

   logic err_now;
   logic err_cur;
   logic err_prev;

   assign err_now = rx_par_err | rx_frm_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_cur  <= 1'b0;
         err_prev <= 1'b0;
      end else if (mframe_start) begin
         err_prev <= err_cur | err_now;
         err_cur  <= 1'b0;
      end else begin
         err_cur  <= err_cur | err_now;
      end
   end

   assign febe_bit = ~err_prev;

   AST_FEBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mframe_start) |-> $stable(febe_bit)); // R5

   AST_FEBE_ERR_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mframe_start && err_now) |=> !febe_bit); // R4

endmodule

// File: rtl/dsc_stuff_seq.sv
module dsc_stuff_seq #(
   parameter int unsigned STUFF_NUM = 7,
   parameter int unsigned STUFF_DEN = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stuff_opp,
   output logic stuff_en
);

   localparam int unsigned SUM_W = $clog2(STUFF_DEN + STUFF_NUM + 1);
   localparam int unsigned WIN_W = $clog2(STUFF_DEN + 1);

   generate
      if (STUFF_DEN == 0 || STUFF_NUM > STUFF_DEN) begin : g_bad_ratio
         $error("stuff ratio must satisfy 0 <= NUM <= DEN, DEN > 0");
      end
   endgenerate

   generate
      if (STUFF_NUM == 0) begin : g_never
         assign stuff_en = 1'b0;
      end else if (STUFF_NUM == STUFF_DEN) begin : g_always
         assign stuff_en = 1'b1;
      end else begin : g_accum
         logic [SUM_W-1:0] acc;
         logic [SUM_W-1:0] sum;
         logic             hit;

         always_comb begin
            sum = acc + SUM_W'(STUFF_NUM);
            hit = (sum >= SUM_W'(STUFF_DEN));
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         acc <= '0;
            else if (stuff_opp) acc <= hit ? (sum - SUM_W'(STUFF_DEN)) : sum;
         end

         assign stuff_en = hit;
      end
   endgenerate

   // window tally for the ratio check
   logic [WIN_W-1:0] win_cnt;
   logic [WIN_W-1:0] win_stf;
   logic             win_last;

   assign win_last = (win_cnt == WIN_W'(STUFF_DEN - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt <= '0;
         win_stf <= '0;
      end else if (stuff_opp) begin
         if (win_last) begin
            win_cnt <= '0;
            win_stf <= '0;
         end else begin
            win_cnt <= win_cnt + WIN_W'(1);
            win_stf <= win_stf + WIN_W'(stuff_en);
         end
      end
   end

   AST_STUFF_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
      (stuff_opp && win_last) |-> ((win_stf + WIN_W'(stuff_en)) == WIN_W'(STUFF_NUM))); // R9

   AST_STUFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stuff_opp) |-> $stable(stuff_en)); // R9

endmodule

// File: rtl/dsc_cbit_gen.sv
module dsc_cbit_gen
   import dsc_cbit_pkg::*;
#(
   parameter int unsigned SUB_W     = 3,
   parameter int unsigned POS_W     = 2,
   parameter int unsigned N_SUB     = 7,
   parameter int unsigned N_POS     = 3,
   parameter int unsigned STUFF_NUM = 7,
   parameter int unsigned STUFF_DEN = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slot_req,
   input  logic [SUB_W-1:0] slot_sub,
   input  logic [POS_W-1:0] slot_pos,
   input  logic             mframe_start,
   input  logic             parity_bit,
   input  logic             feac_bit,
   input  logic             rx_par_err,
   input  logic             rx_frm_err,
   input  logic             dl_data,
   input  logic             dl_valid,
   output logic             dl_ready,
   input  logic             stuff_opp,
   output logic             stuff_en,
   output logic             cbit_out
);

   generate
      if (N_SUB * N_POS != CB_TOTAL) begin : g_bad_frame
         $error("slot grid must cover 21 C-bits");
      end
   endgenerate

   slot_role_e role;
   logic       febe_bit;

   dsc_slot_decode #(
      .SUB_W(SUB_W), .POS_W(POS_W), .N_SUB(N_SUB), .N_POS(N_POS)
   ) u_decode (
      .req  (slot_req),
      .sub  (slot_sub),
      .pos  (slot_pos),
      .role (role)
   );

   dsc_febe_latch u_febe (
      .clk          (clk),
      .rst_n        (rst_n),
      .mframe_start (mframe_start),
      .rx_par_err   (rx_par_err),
      .rx_frm_err   (rx_frm_err),
      .febe_bit     (febe_bit)
   );

   dsc_stuff_seq #(
      .STUFF_NUM(STUFF_NUM), .STUFF_DEN(STUFF_DEN)
   ) u_stuff (
      .clk       (clk),
      .rst_n     (rst_n),
      .stuff_opp (stuff_opp),
      .stuff_en  (stuff_en)
   );

   always_comb begin
      dl_ready = 1'b0;
      unique case (role)
         ROLE_FEAC: cbit_out = feac_bit;
         ROLE_PAR:  cbit_out = parity_bit;
         ROLE_FEBE: cbit_out = febe_bit;
         ROLE_DL: begin
            dl_ready = 1'b1;
            cbit_out = dl_valid ? dl_data : 1'b1;
         end
         default:   cbit_out = 1'b1;
      endcase
   end

   // checks written against the raw slot address, not the decoder
   logic pos_in;
   assign pos_in = (slot_pos >= POS_W'(1)) && (slot_pos <= POS_W'(N_POS));

   AST_FEAC_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && slot_sub == SUB_W'(1) && slot_pos == POS_W'(3)) |-> (cbit_out == feac_bit)); // R2

   AST_PAR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && slot_sub == SUB_W'(3) && pos_in) |-> (cbit_out == parity_bit)); // R3

   AST_DL_READY_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      dl_ready |-> (slot_req && slot_sub == SUB_W'(5) && pos_in)); // R6

   AST_DL_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (dl_ready && !dl_valid) |-> cbit_out); // R6

   AST_IDLE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_req |-> (cbit_out && !dl_ready)); // R8

   AST_OOR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && (slot_sub == '0 || slot_sub > SUB_W'(N_SUB) || !pos_in)) |-> (cbit_out && !dl_ready)); // R8

   AST_UNDEF_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && pos_in && (slot_sub == SUB_W'(2) || slot_sub == SUB_W'(6) || slot_sub == SUB_W'(7))) |-> cbit_out); // R7

endmodule

// File: tb/dsc_cbit_gen_bench.sv
module dsc_cbit_gen_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       slot_req = 1'b0;
   logic [2:0] slot_sub = '0;
   logic [1:0] slot_pos = '0;
   logic       mframe_start = 1'b0;
   logic       parity_bit = 1'b0;
   logic       feac_bit = 1'b0;
   logic       rx_par_err = 1'b0;
   logic       rx_frm_err = 1'b0;
   logic       dl_data = 1'b0;
   logic       dl_valid = 1'b0;
   logic       dl_ready;
   logic       stuff_opp = 1'b0;
   logic       stuff_en;
   logic       cbit_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsc_cbit_gen u_dsc_cbit_gen (
      .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .slot_sub(slot_sub),
      .slot_pos(slot_pos), .mframe_start(mframe_start), .parity_bit(parity_bit),
      .feac_bit(feac_bit), .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err),
      .dl_data(dl_data), .dl_valid(dl_valid), .dl_ready(dl_ready),
      .stuff_opp(stuff_opp), .stuff_en(stuff_en), .cbit_out(cbit_out)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   // drive a slot request at the falling edge, settle, then read
   task automatic ask(input int sub, input int pos);
      @(negedge clk);
      mframe_start = 1'b0;
      rx_par_err   = 1'b0;
      rx_frm_err   = 1'b0;
      slot_req     = 1'b1;
      slot_sub     = sub[2:0];
      slot_pos     = pos[1:0];
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      slot_req = 1'b0;
      mframe_start = 1'b0;
      rx_par_err = 1'b0;
      rx_frm_err = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      idle();
      check("R8 idle cbit", cbit_out, 1'b1);
      check("R8 idle ready", dl_ready, 1'b0);
      check("R9 reset stuff_en", stuff_en, 1'b0);
      ask(4, 1);
      check("R4 febe after reset", cbit_out, 1'b1);
   endtask

   task automatic t_fixed_roles();
      feac_bit = 1'b0;
      ask(1, 1); check("R1 C1", cbit_out, 1'b1);
      ask(1, 2); check("R1 C2", cbit_out, 1'b1);
      ask(1, 3); check("R2 C3 feac=0", cbit_out, 1'b0);
      feac_bit = 1'b1;
      ask(1, 3); check("R2 C3 feac=1", cbit_out, 1'b1);
      feac_bit = 1'b0;
      for (int p = 1; p <= 3; p++) begin
         ask(2, p); check("R7 subframe 2", cbit_out, 1'b1);
         ask(6, p); check("R7 subframe 6", cbit_out, 1'b1);
         ask(7, p); check("R7 subframe 7", cbit_out, 1'b1);
      end
   endtask

   task automatic t_parity();
      for (int p = 1; p <= 3; p++) begin
         parity_bit = 1'b0;
         ask(3, p); check("R3 parity=0", cbit_out, 1'b0);
         parity_bit = 1'b1;
         ask(3, p); check("R3 parity=1", cbit_out, 1'b1);
      end
      parity_bit = 1'b0;
      ask(4, 1); check("R3 parity not on febe", cbit_out, 1'b1);
   endtask

   task automatic pulse_boundary(input logic perr, input logic ferr);
      @(negedge clk);
      slot_req = 1'b0;
      mframe_start = 1'b1;
      rx_par_err = perr;
      rx_frm_err = ferr;
   endtask

   task automatic pulse_err();
      @(negedge clk);
      slot_req = 1'b0;
      rx_par_err = 1'b1;
   endtask

   task automatic t_febe();
      pulse_err();
      idle();
      ask(4, 1); check("R5 error before boundary no change", cbit_out, 1'b1);
      pulse_boundary(1'b0, 1'b0);
      for (int p = 1; p <= 3; p++) begin
         ask(4, p); check("R4 febe after parity err", cbit_out, 1'b0);
      end
      pulse_boundary(1'b0, 1'b0);
      ask(4, 2); check("R5 clean frame clears", cbit_out, 1'b1);
      pulse_boundary(1'b0, 1'b1);
      ask(4, 3); check("R4 framing err on boundary", cbit_out, 1'b0);
      pulse_boundary(1'b0, 1'b0);
      ask(4, 1); check("R5 boundary err not carried", cbit_out, 1'b1);
   endtask

   task automatic t_dlink();
      dl_valid = 1'b1;
      for (int p = 1; p <= 3; p++) begin
         dl_data = p[0];
         ask(5, p);
         check("R6 ready on dl slot", dl_ready, 1'b1);
         check("R6 dl data", cbit_out, p[0]);
      end
      dl_data = 1'b0;
      dl_valid = 1'b0;
      ask(5, 2);
      check("R6 ready without valid", dl_ready, 1'b1);
      check("R6 fill one", cbit_out, 1'b1);
      dl_valid = 1'b1;
      ask(4, 1);
      check("R6 no ready off slot", dl_ready, 1'b0);
      dl_valid = 1'b0;
   endtask

   task automatic t_out_of_range();
      ask(0, 1); check("R8 sub 0", cbit_out, 1'b1);
      dl_valid = 1'b1; dl_data = 1'b0;
      ask(5, 0); check("R8 pos 0", cbit_out, 1'b1);
      check("R8 pos 0 ready", dl_ready, 1'b0);
      ask(5, 3);
      slot_pos = 2'd3; slot_sub = 3'd8 - 3'd1; // C21
      #1; check("R7 C21", cbit_out, 1'b1);
      dl_valid = 1'b0;
      parity_bit = 1'b0;
      ask(3, 0); check("R8 parity pos 0", cbit_out, 1'b1);
      idle(); check("R8 no request", cbit_out, 1'b1);
   endtask

   task automatic t_stuff();
      for (int k = 0; k < 36; k++) begin
         int m;
         logic exp;
         m = k % 18;
         exp = ((((m + 1) * 7) / 18) - ((m * 7) / 18)) != 0;
         @(negedge clk);
         slot_req = 1'b0;
         #1;
         check($sformatf("R9 stuff index %0d", k), stuff_en, exp);
         stuff_opp = 1'b1;
         @(negedge clk);
         stuff_opp = 1'b0;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fixed_roles();
      t_parity();
      t_febe();
      t_dlink();
      t_out_of_range();
      t_stuff();
      idle();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule